// File: doc/BRIEF.md
# Latched-PROM Read Cycle Sequencer

This block sits on the host side of a byte-wide programmable read-only memory. The memory latches its address on the falling edge of an active-low chip enable and drives its data bus only while a separate active-low output enable is low. The host asks for one byte with a single-cycle request and an address. The sequencer then places the address on the memory bus, lowers the chip enable, and after the hold time lowers the output enable. It samples the data bus once both access times have run out. It then raises both enables and waits out the recovery time before starting another read. The captured byte comes back with a one-cycle done pulse.

All memory limits are written in nanoseconds for two speed grades, selected by a parameter. Each limit becomes a count of clock cycles, rounded up, for the clock period given as a parameter. A request that arrives while a read is in progress is kept in a one-entry slot. It is started as soon as the recovery and cycle-time limits allow.

Top module: `prom_rd_seq`

## Requirements
- R1: While reset is high and in the cycle after it, both enables are high (inactive) and done is low.
- R2: The memory address is stable for at least 15 ns (fast grade) or 20 ns (slow grade) before the chip enable falls.
- R3: The memory address does not change for at least 20 ns (fast) or 25 ns (slow) after the chip enable falls.
- R4: The chip enable stays low for at least 95 ns (fast) or 120 ns (slow), and stays high for at least 40 ns between two accesses.
- R5: Two successive chip-enable falling edges are at least 136 ns (fast) or 160 ns (slow) apart.
- R6: The output enable is low only while the chip enable is low, and it is already high in the cycle in which the chip enable rises.
- R7: The data bus is sampled no earlier than 90 ns (fast) or 120 ns (slow) after the chip enable falls, and no earlier than 40 ns (fast) or 50 ns (slow) after the output enable falls. The returned byte is the memory byte at the requested address.
- R8: Done is high for exactly one cycle per read. The returned byte is valid in that cycle and is held until the next capture.
- R9: A request that arrives while a read is busy is held in a one-entry slot and started after recovery. Further requests that arrive while the slot is full are dropped.
- R10: Each phase length is the ceiling of its nanosecond limit divided by the clock period. With a 20 ns clock, a request from idle that is high in cycle c gives done high in cycle c+7 on the fast grade and c+8 on the slow grade.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Single-cycle read request |
| req_addr_i | input | ADDR_W | Address of the requested byte |
| rd_data_o | output | DATA_W | Captured byte |
| done_o | output | 1 | One-cycle pulse, the captured byte is valid |
| mem_addr_o | output | ADDR_W | Address driven to the memory |
| mem_e_n_o | output | 1 | Chip enable, active low |
| mem_g_n_o | output | 1 | Output enable, active low |
| mem_data_i | input | DATA_W | Memory data bus |

## Verification
Isolated reads at several addresses show that the byte captured is the one the memory latched at the chip-enable fall. The memory model returns a poison value until both access times have run out, so sampling too early shows up as wrong data. A second request placed during recovery, and a burst of two requests during an access, separate a correct one-entry hold from dropping the request or queueing too many, and they force back-to-back cycles that test the cycle-time and high-width limits. Both speed grades run side by side. The fixed done latency for each grade shows whether the rounding of nanoseconds to cycles is right.

// File: rtl/prom_rd_pkg.sv
package prom_rd_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ENABLE,
        PH_ACCESS,
        PH_CAPTURE,
        PH_RECOVER
    } phase_e;

    typedef enum int {
        LIM_SETUP,
        LIM_HOLD,
        LIM_ELOW,
        LIM_EHIGH,
        LIM_CYCLE,
        LIM_EACC,
        LIM_GACC
    } limit_e;

    // Memory timing limits in nanoseconds for both speed grades
    function automatic int limit_ns(bit fast, limit_e lim);
        case (lim)
            LIM_SETUP: return fast ? 15  : 20;
            LIM_HOLD:  return fast ? 20  : 25;
            LIM_ELOW:  return fast ? 95  : 120;
            LIM_EHIGH: return 40;
            LIM_CYCLE: return fast ? 136 : 160;
            LIM_EACC:  return fast ? 90  : 120;
            LIM_GACC:  return fast ? 40  : 50;
            default:   return 0;
        endcase
    endfunction

    function automatic int ceil_div(int num, int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int limit_cycles(int period_ns, bit fast, limit_e lim);
        return ceil_div(limit_ns(fast, lim), period_ns);
    endfunction

endpackage

// File: rtl/prom_rd_phase_cnt.sv
module prom_rd_phase_cnt #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/prom_rd_ctrl.sv
module prom_rd_ctrl
    import prom_rd_pkg::*;
#(
    parameter int ADDR_W  = 11,
    parameter int CNT_W   = 3,
    parameter int SETUP_C = 1,
    parameter int HOLD_C  = 1,
    parameter int ACC_C   = 4,
    parameter int CAP_C   = 1,
    parameter int REC_C   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic              cnt_zero_i,
    output logic              cnt_load_o,
    output logic [CNT_W-1:0]  cnt_val_o,
    output logic              addr_load_o,
    output logic [ADDR_W-1:0] addr_val_o,
    output logic              capture_o,
    output phase_e            phase_o
);
    phase_e            phase_q, phase_d;
    logic              pend_q;
    logic [ADDR_W-1:0] pend_addr_q;
    logic              take, start;

    always_comb begin
        take        = (phase_q == PH_IDLE) || ((phase_q == PH_RECOVER) && cnt_zero_i);
        start       = take && (pend_q || req_i);
        addr_val_o  = pend_q ? pend_addr_q : req_addr_i;
        addr_load_o = start;
        phase_d     = phase_q;
        cnt_load_o  = 1'b0;
        cnt_val_o   = '0;
        capture_o   = 1'b0;
        case (phase_q)
            PH_IDLE, PH_RECOVER: begin
                if (start) begin
                    phase_d    = PH_SETUP;
                    cnt_load_o = 1'b1;
                    cnt_val_o  = CNT_W'(SETUP_C - 1);
                end else if (take) begin
                    phase_d = PH_IDLE;
                end
            end
            PH_SETUP: if (cnt_zero_i) begin
                phase_d    = PH_ENABLE;
                cnt_load_o = 1'b1;
                cnt_val_o  = CNT_W'(HOLD_C - 1);
            end
            PH_ENABLE: if (cnt_zero_i) begin
                phase_d    = PH_ACCESS;
                cnt_load_o = 1'b1;
                cnt_val_o  = CNT_W'(ACC_C - 1);
            end
            PH_ACCESS: if (cnt_zero_i) begin
                phase_d    = PH_CAPTURE;
                capture_o  = 1'b1;
                cnt_load_o = 1'b1;
                cnt_val_o  = CNT_W'(CAP_C - 1);
            end
            PH_CAPTURE: if (cnt_zero_i) begin
                phase_d    = PH_RECOVER;
                cnt_load_o = 1'b1;
                cnt_val_o  = CNT_W'(REC_C - 1);
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q     <= PH_IDLE;
            pend_q      <= 1'b0;
            pend_addr_q <= '0;
        end else begin
            phase_q <= phase_d;
            if (take && pend_q) begin
                pend_q <= req_i;
                if (req_i) pend_addr_q <= req_addr_i;
            end else if (take) begin
                pend_q <= 1'b0;
            end else if (!pend_q && req_i) begin
                pend_q      <= 1'b1;
                pend_addr_q <= req_addr_i;
            end
        end
    end

    assign phase_o = phase_q;
endmodule

// File: rtl/prom_rd_datapath.sv
module prom_rd_datapath
    import prom_rd_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_load_i,
    input  logic [ADDR_W-1:0] addr_val_i,
    input  logic              capture_i,
    input  logic [DATA_W-1:0] mem_data_i,
    input  phase_e            phase_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_e_n_o,
    output logic              mem_g_n_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              done_o
);
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            data_q <= '0;
            done_q <= 1'b0;
        end else begin
            if (addr_load_i) addr_q <= addr_val_i;
            if (capture_i)   data_q <= mem_data_i;
            done_q <= capture_i;
        end
    end

    always_comb begin
        mem_e_n_o = !(phase_i inside {PH_ENABLE, PH_ACCESS, PH_CAPTURE});
        mem_g_n_o = (phase_i != PH_ACCESS);
    end

    assign mem_addr_o = addr_q;
    assign rd_data_o  = data_q;
    assign done_o     = done_q;
endmodule

// File: rtl/prom_rd_seq.sv
module prom_rd_seq
    import prom_rd_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 20,
    parameter bit FAST_GRADE    = 1'b1,
    parameter int ADDR_W        = 11,
    parameter int DATA_W        = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_e_n_o,
    output logic              mem_g_n_o,
    input  logic [DATA_W-1:0] mem_data_i
);
    localparam int SETUP_C = imax(1, limit_cycles(CLK_PERIOD_NS, FAST_GRADE, LIM_SETUP));
    localparam int HOLD_C  = imax(1, limit_cycles(CLK_PERIOD_NS, FAST_GRADE, LIM_HOLD));
    localparam int ACC_C   = imax(1, imax(limit_cycles(CLK_PERIOD_NS, FAST_GRADE, LIM_EACC) - HOLD_C,
                                          limit_cycles(CLK_PERIOD_NS, FAST_GRADE, LIM_GACC)));
    localparam int CAP_C   = imax(1, limit_cycles(CLK_PERIOD_NS, FAST_GRADE, LIM_ELOW) - HOLD_C - ACC_C);
    localparam int REC_C   = imax(1, imax(limit_cycles(CLK_PERIOD_NS, FAST_GRADE, LIM_EHIGH),
                                          limit_cycles(CLK_PERIOD_NS, FAST_GRADE, LIM_CYCLE)
                                          - SETUP_C - HOLD_C - ACC_C - CAP_C));
    localparam int MAX_C   = imax(imax(SETUP_C, HOLD_C), imax(imax(ACC_C, CAP_C), REC_C));
    localparam int CNT_W   = imax(1, $clog2(MAX_C));

    logic              cnt_zero, cnt_load, addr_load, capture;
    logic [CNT_W-1:0]  cnt_val;
    logic [ADDR_W-1:0] addr_val;
    phase_e            phase;

    prom_rd_phase_cnt #(.CNT_W(CNT_W)) cnt_i (
        .clk        (clk),
        .rst        (rst),
        .load_i     (cnt_load),
        .load_val_i (cnt_val),
        .zero_o     (cnt_zero)
    );

    prom_rd_ctrl #(
        .ADDR_W  (ADDR_W),
        .CNT_W   (CNT_W),
        .SETUP_C (SETUP_C),
        .HOLD_C  (HOLD_C),
        .ACC_C   (ACC_C),
        .CAP_C   (CAP_C),
        .REC_C   (REC_C)
    ) ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .req_i       (req_i),
        .req_addr_i  (req_addr_i),
        .cnt_zero_i  (cnt_zero),
        .cnt_load_o  (cnt_load),
        .cnt_val_o   (cnt_val),
        .addr_load_o (addr_load),
        .addr_val_o  (addr_val),
        .capture_o   (capture),
        .phase_o     (phase)
    );

    prom_rd_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
        .clk         (clk),
        .rst         (rst),
        .addr_load_i (addr_load),
        .addr_val_i  (addr_val),
        .capture_i   (capture),
        .mem_data_i  (mem_data_i),
        .phase_i     (phase),
        .mem_addr_o  (mem_addr_o),
        .mem_e_n_o   (mem_e_n_o),
        .mem_g_n_o   (mem_g_n_o),
        .rd_data_o   (rd_data_o),
        .done_o      (done_o)
    );
endmodule

// File: rtl/prom_rd_seq_chk.sv
module prom_rd_seq_chk
    import prom_rd_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 20,
    parameter bit FAST_GRADE    = 1'b1,
    parameter int ADDR_W        = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              e_n,
    input logic              g_n,
    input logic [ADDR_W-1:0] addr,
    input logic              done
);
    localparam int ELOW_C  = limit_cycles(CLK_PERIOD_NS, FAST_GRADE, LIM_ELOW);
    localparam int EHIGH_C = limit_cycles(CLK_PERIOD_NS, FAST_GRADE, LIM_EHIGH);
    localparam int CYC_C   = limit_cycles(CLK_PERIOD_NS, FAST_GRADE, LIM_CYCLE);

    logic [15:0] low_cnt, high_cnt, since_fall;
    logic        e_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt    <= '0;
            high_cnt   <= 16'(EHIGH_C);
            since_fall <= 16'(CYC_C);
            e_d        <= 1'b1;
        end else begin
            e_d        <= e_n;
            low_cnt    <= !e_n ? ((low_cnt == 16'hFFFF) ? low_cnt : low_cnt + 1'b1) : '0;
            high_cnt   <= e_n ? ((high_cnt == 16'hFFFF) ? high_cnt : high_cnt + 1'b1) : '0;
            since_fall <= (e_d && !e_n) ? 16'd1
                        : ((since_fall == 16'hFFFF) ? since_fall : since_fall + 1'b1);
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) rst |=> (e_n && g_n && !done));

    // R2
    addr_setup_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(e_n) |-> $stable(addr));

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!e_n && $past(!e_n)) |-> $stable(addr));

    // R4
    e_low_width_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(e_n) |-> (low_cnt >= 16'(ELOW_C)));

    // R4
    e_high_width_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(e_n) |-> (high_cnt >= 16'(EHIGH_C)));

    // R5
    cycle_time_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(e_n) |-> (since_fall >= 16'(CYC_C)));

    // R6
    g_inside_e_chk: assert property (@(posedge clk) disable iff (rst)
        !g_n |-> !e_n);

    // R6
    g_up_at_e_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(e_n) |-> g_n);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

bind prom_rd_seq prom_rd_seq_chk #(
    .CLK_PERIOD_NS (CLK_PERIOD_NS),
    .FAST_GRADE    (FAST_GRADE),
    .ADDR_W        (ADDR_W)
) chk_i (
    .clk  (clk),
    .rst  (rst),
    .e_n  (mem_e_n_o),
    .g_n  (mem_g_n_o),
    .addr (mem_addr_o),
    .done (done_o)
);

// File: tb/prom_rd_seq_tb_mem.sv
module prom_rd_seq_tb_mem #(
    parameter int P        = 20,
    parameter int SETUP_NS = 15,
    parameter int HOLD_NS  = 20,
    parameter int ELOW_NS  = 95,
    parameter int EHIGH_NS = 40,
    parameter int CYC_NS   = 136,
    parameter int EACC_NS  = 90,
    parameter int GACC_NS  = 40
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        e_n,
    input  logic        g_n,
    input  logic [10:0] addr,
    input  logic        done,
    input  logic [7:0]  rd_data,
    output logic [7:0]  data,
    output int          n_chk,
    output int          n_fail
);
    function automatic logic [7:0] rom(logic [10:0] a);
        return 8'(a[7:0] * 8'd7) ^ {5'b0, a[10:8]} ^ 8'h3C;
    endfunction

    logic        prev_e, first, hold_bad, g_bad;
    logic [10:0] prev_addr, fall_addr;
    int          stable, low, glow, high, since;

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s grade-ns-cycle=%0d memory-side actual=%0d expected=%0d", req, CYC_NS, act, exp);
        end
    endtask

    initial begin
        n_chk = 0; n_fail = 0; data = 8'hEE;
        prev_e = 1'b1; first = 1'b1; prev_addr = '0; fall_addr = '0;
        stable = 0; low = 0; glow = 0; high = 0; since = 0; hold_bad = 0; g_bad = 0;
    end

    always @(negedge clk) begin
        if (rst) begin
            data = 8'hEE; prev_e = 1'b1; first = 1'b1; prev_addr = addr; stable = 0;
            high = 0; since = 0;
        end else begin
            stable = (addr == prev_addr) ? stable + 1 : 0;
            if (!e_n && prev_e) begin
                chk((stable * P) >= SETUP_NS, "R2 address setup before E fall", stable * P, SETUP_NS);
                if (!first) begin
                    chk((high * P) >= EHIGH_NS, "R4 E high width", high * P, EHIGH_NS);
                    chk((since * P) >= CYC_NS, "R5 E fall to E fall", since * P, CYC_NS);
                end
                first = 1'b0; fall_addr = addr; low = 0; glow = 0; since = 0;
                hold_bad = 1'b0; g_bad = 1'b0;
            end
            if (!e_n) begin
                if ((low * P) < HOLD_NS && addr != fall_addr) hold_bad = 1'b1;
                low++;
                if (!g_n) glow++;
            end
            if (!g_n && e_n) g_bad = 1'b1;
            if (e_n && !prev_e) begin
                chk(!hold_bad, "R3 address hold after E fall", int'(hold_bad), 0);
                chk((low * P) >= ELOW_NS, "R4 E low width", low * P, ELOW_NS);
                chk(!g_bad && g_n, "R6 G high when E rises", int'(g_bad || !g_n), 0);
                high = 0;
            end
            if (e_n) high++;
            since++;
            data = (!e_n && !g_n && (low * P) >= EACC_NS && (glow * P) >= GACC_NS)
                   ? rom(fall_addr) : 8'hEE;
            if (done) chk(rd_data == rom(fall_addr), "R7 byte after access times", int'(rd_data),
                          int'(rom(fall_addr)));
            prev_e = e_n; prev_addr = addr;
        end
    end
endmodule

// File: tb/prom_rd_seq_tb_top.sv
module prom_rd_seq_tb_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst;
    logic        req [2];
    logic [10:0] raddr [2];
    logic [7:0]  rdata [2];
    logic        done [2];
    logic [10:0] maddr [2];
    logic        en [2];
    logic        gn [2];
    logic [7:0]  mdata [2];
    int          mchk [2];
    int          mfail [2];

    int checks = 0;
    int fails  = 0;
    int wd     = 0;

    function automatic logic [7:0] rom(logic [10:0] a);
        return 8'(a[7:0] * 8'd7) ^ {5'b0, a[10:8]} ^ 8'h3C;
    endfunction

    prom_rd_seq #(.CLK_PERIOD_NS(20), .FAST_GRADE(1'b1)) dut_i (
        .clk(clk), .rst(rst), .req_i(req[0]), .req_addr_i(raddr[0]), .rd_data_o(rdata[0]),
        .done_o(done[0]), .mem_addr_o(maddr[0]), .mem_e_n_o(en[0]), .mem_g_n_o(gn[0]),
        .mem_data_i(mdata[0]));

    prom_rd_seq #(.CLK_PERIOD_NS(20), .FAST_GRADE(1'b0)) dut_slow_i (
        .clk(clk), .rst(rst), .req_i(req[1]), .req_addr_i(raddr[1]), .rd_data_o(rdata[1]),
        .done_o(done[1]), .mem_addr_o(maddr[1]), .mem_e_n_o(en[1]), .mem_g_n_o(gn[1]),
        .mem_data_i(mdata[1]));

    prom_rd_seq_tb_mem #(.P(20), .SETUP_NS(15), .HOLD_NS(20), .ELOW_NS(95), .EHIGH_NS(40),
                         .CYC_NS(136), .EACC_NS(90), .GACC_NS(40)) mem_fast_i (
        .clk(clk), .rst(rst), .e_n(en[0]), .g_n(gn[0]), .addr(maddr[0]), .done(done[0]),
        .rd_data(rdata[0]), .data(mdata[0]), .n_chk(mchk[0]), .n_fail(mfail[0]));

    prom_rd_seq_tb_mem #(.P(20), .SETUP_NS(20), .HOLD_NS(25), .ELOW_NS(120), .EHIGH_NS(40),
                         .CYC_NS(160), .EACC_NS(120), .GACC_NS(50)) mem_slow_i (
        .clk(clk), .rst(rst), .e_n(en[1]), .g_n(gn[1]), .addr(maddr[1]), .done(done[1]),
        .rd_data(rdata[1]), .data(mdata[1]), .n_chk(mchk[1]), .n_fail(mfail[1]));

    task automatic check(bit ok, string req_tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks + mchk[0] + mchk[1],
                 fails + mfail[0] + mfail[1]);
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 20000) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", wd, 20000);
            summary();
            $finish;
        end
    end

    // R1: enables idle high and done low after reset
    task automatic t_reset();
        rst = 1'b1;
        for (int g = 0; g < 2; g++) begin req[g] = 1'b0; raddr[g] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        for (int g = 0; g < 2; g++) begin
            check(en[g] && gn[g], "R1 enables high after reset", int'({en[g], gn[g]}), 3);
            check(!done[g], "R1 done low after reset", int'(done[g]), 0);
        end
    endtask

    // R7 R8 R10: a read from idle
    task automatic t_single(int g, logic [10:0] a);
        int lat;
        int exp_lat;
        exp_lat = (g == 0) ? 7 : 8;
        lat = 0;
        @(negedge clk);
        req[g] = 1'b1; raddr[g] = a;
        for (int n = 1; n <= 40; n++) begin
            @(negedge clk);
            req[g] = 1'b0;
            if (done[g]) begin lat = n; break; end
        end
        check(lat == exp_lat, "R10 done latency from idle", lat, exp_lat);
        check(rdata[g] == rom(a), "R7 returned byte", int'(rdata[g]), int'(rom(a)));
        @(negedge clk);
        check(!done[g], "R8 done lasts one cycle", int'(done[g]), 0);
        check(rdata[g] == rom(a), "R8 byte held after done", int'(rdata[g]), int'(rom(a)));
        repeat (6) @(negedge clk);
    endtask

    // R9: request during recovery is held and served
    task automatic t_recover_req(int g, logic [10:0] a1, logic [10:0] a2);
        int seen;
        seen = 0;
        @(negedge clk);
        req[g] = 1'b1; raddr[g] = a1;
        for (int n = 0; n < 40; n++) begin
            @(negedge clk);
            req[g] = 1'b0;
            if (done[g]) break;
        end
        check(rdata[g] == rom(a1), "R7 first byte", int'(rdata[g]), int'(rom(a1)));
        @(negedge clk);
        req[g] = 1'b1; raddr[g] = a2;
        for (int n = 0; n < 40; n++) begin
            @(negedge clk);
            req[g] = 1'b0;
            if (done[g]) begin seen = 1; break; end
        end
        check(seen == 1, "R9 request in recovery served", seen, 1);
        check(rdata[g] == rom(a2), "R9 byte of held request", int'(rdata[g]), int'(rom(a2)));
        repeat (10) @(negedge clk);
    endtask

    // R9: one request held, a second one while the slot is full is dropped
    task automatic t_queue(int g, logic [10:0] a1, logic [10:0] a2, logic [10:0] a3);
        int cnt;
        logic [7:0] got [2];
        cnt = 0; got[0] = '0; got[1] = '0;
        @(negedge clk);
        req[g] = 1'b1; raddr[g] = a1;
        for (int i = 1; i <= 60; i++) begin
            @(negedge clk);
            req[g] = 1'b0;
            if (i == 3) begin req[g] = 1'b1; raddr[g] = a2; end
            if (i == 4) begin req[g] = 1'b1; raddr[g] = a3; end
            if (done[g]) begin
                if (cnt < 2) got[cnt] = rdata[g];
                cnt++;
            end
        end
        check(cnt == 2, "R9 dones for three requests with full slot", cnt, 2);
        check(got[0] == rom(a1), "R9 first byte in burst", int'(got[0]), int'(rom(a1)));
        check(got[1] == rom(a2), "R9 held byte in burst", int'(got[1]), int'(rom(a2)));
        repeat (5) @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_single(0, 11'h000);
        t_single(0, 11'h7FF);
        t_single(0, 11'h2A5);
        t_single(1, 11'h000);
        t_single(1, 11'h5C3);
        t_single(1, 11'h7FE);
        t_recover_req(0, 11'h123, 11'h456);
        t_recover_req(1, 11'h321, 11'h654);
        t_queue(0, 11'h011, 11'h622, 11'h133);
        t_queue(1, 11'h744, 11'h055, 11'h266);
        t_single(0, 11'h400);
        summary();
        $finish;
    end
endmodule